// File: doc/BRIEF.md
# Single-Cycle 16-Bit Two-Operand Processor

This block is a small processor that finishes one instruction on every clock edge. Words are 16 bits wide and there are eight general registers. Each instruction names at most two registers, and the first one is both a source and the destination. The instruction store and the data store are separate internal arrays of 256 words each. Both are addressed by word with an 8-bit address.

Code is written into the instruction store through a simple write port, normally while reset is held. After reset is released the core runs from address 0. The core does register arithmetic and logic, adds an 8-bit immediate, loads and stores data words, takes branches to absolute targets based on the sign or zero of one register, jumps with or without a link, and copies a register to a display output. A halt instruction freezes the core until the next reset.

Top module: `umc_core`

## Requirements
- R1: A synchronous active-low reset clears the PC, all eight registers, the display output and the halted flag.
- R2: Instruction fields are: opcode in bits 15:12, Rs in bits 11:9, subop in bit 8, immediate in bits 7:0, and Rt in bits 7:5 for register forms. Bits 4:0 of register forms are ignored.
- R3: Opcodes 0 to 4 compute Rs = Rs op Rt, where op is add, subtract, and, or and xor in that order.
- R4: Opcode 6 computes Rs = Rs + imm. The immediate is zero-extended when subop is 0 and sign-extended when subop is 1.
- R5: Opcode 7 loads Rs from data word Rt[7:0]. Opcode 8 stores Rs into data word Rt[7:0]. Bits 15:8 of Rt are ignored.
- R6: Opcodes 9, A, B and C branch to the absolute target imm when Rs is zero, non-zero, negative or strictly positive respectively. Otherwise the PC steps by one.
- R7: Opcode D jumps to imm. When subop is 1, it first writes PC+1, zero-extended, into register 7.
- R8: Opcode E copies Rs to the display output. No other instruction changes the display output.
- R9: Opcode F raises halted. While halted, the PC, the registers, the data store and the display output do not change.
- R10: Opcode 5 changes nothing except advancing the PC by one.
- R11: Arithmetic wraps modulo 2^16. Results read as two's complement give correct signed values.
- R12: A write strobe on the load port stores the given word at the given instruction address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Write strobe for the instruction store |
| imem_addr | input | 8 | Instruction store write address |
| imem_wdata | input | 16 | Instruction word to write |
| disp_out | output | 16 | Display register, written by put |
| halted | output | 1 | High once a halt has executed |

## Verification
The bench goes after the branch conditions at their edges. A zero register must not count as positive, so a core that tests "not negative" for the positive branch takes that branch wrongly and shows a different final value. The immediate with bit 7 set separates sign extension from zero extension, and a core that ignores the subop bit gives the wrong high byte. A store through a register whose high byte is set checks the 8-bit address mask, because an unmasked address misses the word read back later. Further tests cover freezing after halt, reset clearing registers that a previous program left non-zero, and the link value of the jump-and-link.

// File: rtl/umc_pkg.sv
// Shared encodings for the single-cycle core.
// Assumes a 16-bit instruction word with fixed field positions.
package umc_pkg;
    localparam int XLEN = 16;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);
    localparam int LINK_REG = NREG - 1;

    typedef enum logic [3:0] {
        OP_ADD = 4'h0, OP_SUB = 4'h1, OP_AND = 4'h2, OP_OR = 4'h3,
        OP_XOR = 4'h4, OP_RSV = 4'h5, OP_ADDI = 4'h6, OP_LOAD = 4'h7,
        OP_STORE = 4'h8, OP_BZ = 4'h9, OP_BNZ = 4'hA, OP_BN = 4'hB,
        OP_BP = 4'hC, OP_JMP = 4'hD, OP_PUT = 4'hE, OP_HALT = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR
    } alu_op_e;

    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

    typedef enum logic [2:0] {
        BR_NONE, BR_Z, BR_NZ, BR_N, BR_P, BR_ALWAYS
    } br_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;
        logic    reg_we;
        wb_sel_e wb_sel;
        logic    mem_we;
        logic    put;
        logic    halt;
        br_e     br;
    } ctrl_t;
endpackage

// File: rtl/umc_decode.sv
// Instruction decoder: splits the word into fields and derives control.
// Assumes the field layout of umc_pkg; unknown opcodes decode to a no-op.
module umc_decode
    import umc_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output ctrl_t           ctrl,
    output logic [RIDX-1:0] rs,
    output logic [RIDX-1:0] rt,
    output logic            subop,
    output logic [7:0]      imm
);
    opcode_e op;

    // Field extraction.
    always_comb begin
        op    = opcode_e'(insn[15:12]);
        rs    = insn[11:9];
        subop = insn[8];
        imm   = insn[7:0];
        rt    = insn[7:5];
    end

    // Control table, one opcode per arm.
    always_comb begin
        ctrl = '{alu_op: ALU_ADD, use_imm: 1'b0, reg_we: 1'b0, wb_sel: WB_ALU,
                 mem_we: 1'b0, put: 1'b0, halt: 1'b0, br: BR_NONE};
        unique case (op)
            OP_ADD:   ctrl.reg_we = 1'b1;
            OP_SUB:   begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
            OP_AND:   begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
            OP_OR:    begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_OR;  end
            OP_XOR:   begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_XOR; end
            OP_ADDI:  begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
            OP_LOAD:  begin ctrl.reg_we = 1'b1; ctrl.wb_sel = WB_MEM; end
            OP_STORE: ctrl.mem_we = 1'b1;
            OP_BZ:    ctrl.br = BR_Z;
            OP_BNZ:   ctrl.br = BR_NZ;
            OP_BN:    ctrl.br = BR_N;
            OP_BP:    ctrl.br = BR_P;
            OP_JMP:   begin ctrl.br = BR_ALWAYS; ctrl.reg_we = subop; ctrl.wb_sel = WB_LINK; end
            OP_PUT:   ctrl.put = 1'b1;
            OP_HALT:  ctrl.halt = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/umc_alu.sv
// Two-input ALU. Results wrap at the word width; no flags are produced.
module umc_alu
    import umc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    // Operation select.
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/umc_regfile.sv
// Register file: two combinational read ports and one write port.
// Assumes a synchronous active-low reset that clears every entry.
module umc_regfile #(
    parameter int W = 16,
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    // Clear on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    // Read ports.
    always_comb begin
        qa = regs[ra];
        qb = regs[rb];
    end
endmodule

// File: rtl/umc_core.sv
// Single-cycle core: fetch, decode, execute and write back in one clock.
// Assumes the instruction store is filled through the load port before
// reset is released. The data store is not cleared by reset.
module umc_core
    import umc_pkg::*;
#(
    parameter int IMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 256,
    localparam int IAW = $clog2(IMEM_DEPTH),
    localparam int DAW = $clog2(DMEM_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imem_we,
    input  logic [IAW-1:0]  imem_addr,
    input  logic [XLEN-1:0] imem_wdata,
    output logic [XLEN-1:0] disp_out,
    output logic            halted
);
    logic [XLEN-1:0] imem [IMEM_DEPTH];
    logic [XLEN-1:0] dmem [DMEM_DEPTH];
    logic [IAW-1:0]  pc_q, pc_next, pc_inc;
    logic [XLEN-1:0] insn, rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data;
    logic [RIDX-1:0] rs, rt, wa;
    logic [7:0]      imm;
    logic            subop, run, taken;
    ctrl_t           ctrl;

    assign run    = !halted;
    assign insn   = imem[pc_q];
    assign pc_inc = pc_q + 1'b1;

    umc_decode u_dec (
        .insn(insn), .ctrl(ctrl), .rs(rs), .rt(rt), .subop(subop), .imm(imm)
    );

    umc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .ra(rs), .rb(rt), .qa(rs_val), .qb(rt_val),
        .we(run && ctrl.reg_we), .wa(wa), .wd(wb_data)
    );

    umc_alu #(.W(XLEN)) u_alu (.a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y));

    // Operand selection and immediate extension.
    always_comb begin
        imm_ext = subop ? {{(XLEN-8){imm[7]}}, imm} : {{(XLEN-8){1'b0}}, imm};
        alu_b   = ctrl.use_imm ? imm_ext : rt_val;
    end

    // Write-back source and destination.
    always_comb begin
        wa = (ctrl.wb_sel == WB_LINK) ? RIDX'(LINK_REG) : rs;
        unique case (ctrl.wb_sel)
            WB_MEM:  wb_data = dmem[rt_val[DAW-1:0]];
            WB_LINK: wb_data = XLEN'(pc_inc);
            default: wb_data = alu_y;
        endcase
    end

    // Branch condition on the first register.
    always_comb begin
        unique case (ctrl.br)
            BR_Z:      taken = (rs_val == '0);
            BR_NZ:     taken = (rs_val != '0);
            BR_N:      taken = rs_val[XLEN-1];
            BR_P:      taken = !rs_val[XLEN-1] && (rs_val != '0);
            BR_ALWAYS: taken = 1'b1;
            default:   taken = 1'b0;
        endcase
        pc_next = taken ? IAW'(imm) : pc_inc;
    end

    // Instruction store load port.
    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_addr] <= imem_wdata;
    end

    // Data store write.
    always_ff @(posedge clk) begin
        if (rst_n && run && ctrl.mem_we) dmem[rt_val[DAW-1:0]] <= rs_val;
    end

    // PC, display and halted state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            disp_out <= '0;
            halted   <= 1'b0;
        end else if (run) begin
            if (ctrl.halt) halted <= 1'b1;
            else           pc_q   <= pc_next;
            if (ctrl.put)  disp_out <= rs_val;
        end
    end
endmodule

// File: rtl/umc_core_chk.sv
// Property checker for umc_core, attached with bind below.
module umc_core_chk #(
    parameter int IAW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           halted,
    input logic [IAW-1:0] pc,
    input logic [15:0]    insn,
    input logic [15:0]    disp
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !halted && disp == '0));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9
    halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || insn[15:12] == 4'hF) |=> $stable(pc));

    // R8
    disp_put_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || insn[15:12] != 4'hE) |=> $stable(disp));

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && (insn[15:12] < 4'h9 || insn[15:12] == 4'hE))
        |=> pc == IAW'($past(pc) + 1'b1));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && insn[15:12] == 4'hD) |=> pc == IAW'($past(insn[7:0])));
endmodule

bind umc_core umc_core_chk #(.IAW(IAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .halted(halted), .pc(pc_q),
    .insn(insn), .disp(disp_out)
);

// File: tb/sim_umc_core.sv
module sim_umc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [7:0]  imem_addr = '0;
    logic [15:0] imem_wdata = '0;
    logic [15:0] disp_out;
    logic        halted;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    umc_core u0 (
        .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .disp_out(disp_out), .halted(halted)
    );

    // Each row: six program words then the expected display value.
    localparam int NV = 18;
    localparam logic [111:0] VEC [NV] = '{
        {16'h6205, 16'h6403, 16'h0240, 16'hE200, 16'h0000, 16'h0000, 16'h0008}, // R3 add, R12
        {16'h6205, 16'h6403, 16'h1240, 16'hE200, 16'h0000, 16'h0000, 16'h0002}, // R3 sub
        {16'h6203, 16'h6405, 16'h1240, 16'hE200, 16'h0000, 16'h0000, 16'hFFFE}, // R11 negative
        {16'h6380, 16'h6480, 16'h4240, 16'hE200, 16'h0000, 16'h0000, 16'hFF00}, // R4 sext vs zext, xor
        {16'h620C, 16'h640A, 16'h2240, 16'hE200, 16'h0000, 16'h0000, 16'h0008}, // R3 and
        {16'h620C, 16'h640A, 16'h3240, 16'hE200, 16'h0000, 16'h0000, 16'h000E}, // R3 or
        {16'h63FF, 16'h6201, 16'hE200, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R11 wrap
        {16'h6277, 16'h6410, 16'h8240, 16'h7640, 16'hE600, 16'h0000, 16'h0077}, // R5 store/load
        {16'h6255, 16'h6590, 16'h8240, 16'h6890, 16'h7680, 16'hE600, 16'h0055}, // R5 mask, R2
        {16'h6205, 16'h5240, 16'hE200, 16'h0000, 16'h0000, 16'h0000, 16'h0005}, // R10 reserved
        {16'h6200, 16'h9204, 16'h6211, 16'hE200, 16'h6222, 16'hE200, 16'h0022}, // R6 bz taken
        {16'h6200, 16'hA204, 16'h6211, 16'hE200, 16'h6222, 16'hE200, 16'h0033}, // R6 bnz not taken
        {16'h6205, 16'hA204, 16'h6211, 16'hE200, 16'h6222, 16'hE200, 16'h0027}, // R6 bnz taken
        {16'h63FF, 16'hB204, 16'h6211, 16'hE200, 16'h6222, 16'hE200, 16'h0021}, // R6 bn taken
        {16'h63FF, 16'hC204, 16'h6211, 16'hE200, 16'h6222, 16'hE200, 16'h0032}, // R6 bp negative
        {16'h6200, 16'hC204, 16'h6211, 16'hE200, 16'h6222, 16'hE200, 16'h0033}, // R6 bp zero
        {16'hD104, 16'h6E11, 16'h6E11, 16'h6E11, 16'hEE00, 16'h0000, 16'h0001}, // R7 jal link
        {16'hD004, 16'h6E11, 16'h6E11, 16'h6E11, 16'hEE00, 16'h0000, 16'h0000}  // R7 plain jump
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        imem_we = 1'b1; imem_addr = a; imem_wdata = d;
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    // Load a program under reset, release, wait for halt.
    task automatic run_prog(input logic [95:0] prog, output bit done);
        rst_n = 1'b0;
        for (int k = 0; k < 6; k++) put_word(8'(k), prog[95-16*k -: 16]);
        put_word(8'd6, 16'hF000);
        put_word(8'd7, 16'hF000);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b0;
        for (int c = 0; c < 60 && !done; c++) begin
            @(negedge clk);
            if (halted) done = 1'b1;
        end
    endtask

    initial begin
        bit done;
        // R1 reset state
        repeat (2) @(negedge clk);
        check(disp_out == 16'h0 && !halted, "R1 reset", {halted, disp_out[14:0]}, 16'h0);

        for (int v = 0; v < NV; v++) begin
            run_prog(VEC[v][111:16], done);
            check(done, "R9 halt reached", 16'(done), 16'h1);
            check(disp_out == VEC[v][15:0], $sformatf("vector %0d", v), disp_out, VEC[v][15:0]);
        end

        // R1 reset clears display and halted after a run.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(disp_out == 16'h0, "R1 disp cleared", disp_out, 16'h0);
        check(!halted, "R1 halted cleared", 16'(halted), 16'h0);

        // R9 halt freezes: put after halt must never happen.
        run_prog({16'h6205, 16'hF000, 16'h6205, 16'hE200, 16'hE200, 16'h0000}, done);
        repeat (10) @(negedge clk);
        check(halted, "R9 stays halted", 16'(halted), 16'h1);
        check(disp_out == 16'h0, "R9 frozen after halt", disp_out, 16'h0);

        // R1 registers cleared: r1 was 5 in the previous program.
        run_prog({16'hE200, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, done);
        check(disp_out == 16'h0, "R1 register cleared", disp_out, 16'h0);

        // R2 ignored low bits of register form: add with bits 4:0 set.
        run_prog({16'h6205, 16'h6403, 16'h025F, 16'hE200, 16'h0000, 16'h0000}, done);
        check(disp_out == 16'h0008, "R2 low bits ignored", disp_out, 16'h0008);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule